// File: doc/BRIEF.md
# Physical Memory Protection Checker

This combinational block decides whether a single memory access may proceed, given a small table of protection regions. Each access presents a physical start address, a byte count, an access kind (read, write or execute) and a flag saying whether the hart runs in machine mode. The table arrives from a neighbouring register-file block as, for every entry, an inclusive lower bound, an exclusive upper bound and an 8-bit configuration byte. The configuration byte carries read, write and execute permissions in bits 0, 1 and 2, an address-mode field in bits 4:3 (zero means the entry is off), and a lock bit in bit 7.

The block answers in the same cycle with an allow/fault pair and a 2-bit cause code. The core's trap logic uses this code to pick a load, store or instruction access fault. Entries are scanned from index 0 upward, and the first active entry that wholly contains the access decides the result. The entry count, address width and size-field width are parameters.

Top module: `pmp_checker`

## Requirements
- R1: An entry matches only when the start address is at or above its lower bound and the last byte (start + size − 1, computed without wrap-around) is below its exclusive upper bound. A size of 0 is treated as a one-byte access.
- R2: An entry whose address-mode field, cfg bits 4:3, equals 0 never matches, whatever its bounds and permission bits.
- R3: When several active entries match, only the one with the lowest index decides the outcome; higher-indexed entries have no effect.
- R4: In machine mode (priv_m = 1), a matching entry whose lock bit, cfg bit 7, is clear allows the access regardless of its permission bits.
- R5: Otherwise the matching entry allows a read (acc_kind 0) only with cfg bit 0 set, and a write (acc_kind 1) only with cfg bit 1 set. It allows an execute (acc_kind 2, and the reserved value 3 treated as execute) only with cfg bit 2 set. Any other combination faults.
- R6: When no active entry matches, a machine-mode access is allowed and a lower-privilege access faults.
- R7: The check is bypassed and the access allowed when no entry has a nonzero address-mode field, or when the access is in machine mode and no entry at all (active or off) has its lock bit set.
- R8: fault is always the inverse of allow. cause is 0 when allowed, and on a fault is 1 for a read, 2 for a write and 3 for an execute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_addr | input | ADDR_W | Physical start address of the access |
| acc_size | input | SIZE_W | Access length in bytes (0 treated as 1) |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 treated as execute |
| priv_m | input | 1 | 1 when the access is made in machine mode |
| region_lo | input | NUM_ENTRIES*ADDR_W | Inclusive lower bound per entry, entry i at bits [i*ADDR_W +: ADDR_W] |
| region_hi | input | NUM_ENTRIES*ADDR_W | Exclusive upper bound per entry, same packing |
| region_cfg | input | NUM_ENTRIES*8 | Configuration byte per entry, entry i at bits [i*8 +: 8] |
| allow | output | 1 | Access may proceed |
| fault | output | 1 | Access is refused |
| cause | output | 2 | 0 none, 1 load fault, 2 store fault, 3 instruction fault |

## Verification
The hardest situation to reach is an access that lies fully inside two active entries with different lock and permission settings, while the machine-mode bypass is not in force because some unrelated entry is locked. Random region tables rarely produce this. Directed cases therefore stack identical ranges at neighbouring indices, and place a lock on an entry that is off. The random phase squeezes every region and address into a 1.25 KiB window, so overlaps, straddles and exact-boundary hits come up often. It also draws sizes that cross upper bounds by a single byte.

// File: rtl/pmpc_pkg.sv
// Package: pmpc_pkg
// Shared encodings for the protection checker: configuration byte bit
// positions, access-kind codes and fault-cause codes.
// Assumes the configuration byte layout used by the register-file block.
package pmpc_pkg;

    // Configuration byte bit positions
    localparam int CFG_R_BIT    = 0;
    localparam int CFG_W_BIT    = 1;
    localparam int CFG_X_BIT    = 2;
    localparam int CFG_MODE_LSB = 3;
    localparam int CFG_MODE_MSB = 4;
    localparam int CFG_LOCK_BIT = 7;

    // Access kinds presented on acc_kind
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_t;

    // Fault cause codes
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_LOAD  = 2'd1,
        CAUSE_STORE = 2'd2,
        CAUSE_INSTR = 2'd3
    } cause_t;

    // Permission triple of one entry
    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

endpackage

// File: rtl/pmpc_entry_match.sv
// Module: pmpc_entry_match
// Compares one access against one protection entry. Reports whether the
// entry is active, whether it fully contains the access, and breaks out
// the lock and permission bits.
// Assumes addr_last has already been computed one bit wider than the
// address so that a carry past the top of the space is kept.
module pmpc_entry_match
    import pmpc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_first,
    input  logic [ADDR_W:0]   addr_last,
    input  logic [ADDR_W-1:0] bound_lo,
    input  logic [ADDR_W-1:0] bound_hi,
    input  logic [7:0]        cfg,
    output logic              active,
    output logic              hit,
    output logic              locked,
    output perm_t             perm
);

    logic [ADDR_W:0] lo_ext;
    logic [ADDR_W:0] hi_ext;
    logic [ADDR_W:0] first_ext;
    logic            first_in;
    logic            last_in;

    // Field extraction from the configuration byte
    always_comb begin
        active = (cfg[CFG_MODE_MSB:CFG_MODE_LSB] != 2'b00);
        locked = cfg[CFG_LOCK_BIT];
        perm.r = cfg[CFG_R_BIT];
        perm.w = cfg[CFG_W_BIT];
        perm.x = cfg[CFG_X_BIT];
    end

    // Bound comparison on widened operands, upper bound exclusive
    always_comb begin
        lo_ext    = {1'b0, bound_lo};
        hi_ext    = {1'b0, bound_hi};
        first_ext = {1'b0, addr_first};
        first_in  = (first_ext >= lo_ext);
        last_in   = (addr_last < hi_ext);
        hit       = active && first_in && last_in;
    end

    // An inactive entry must never report a hit (R2); a hit lies within bounds (R1)
    always_comb begin
        assert_off_no_hit_R2: assert (!(hit && (cfg[4:3] == 2'b00)))
            else $error("off entry reported a hit");
        assert_hit_in_bounds_R1: assert (!hit || ((addr_first >= bound_lo) && (addr_last < {1'b0, bound_hi})))
            else $error("hit outside the entry bounds");
    end

endmodule

// File: rtl/pmpc_first_hit.sv
// Module: pmpc_first_hit
// Lowest-index-first selector: grants the lowest set request bit and
// reports its index and whether any request was present.
// Assumes nothing about the number of set request bits.
module pmpc_first_hit #(
    parameter int NUM = 16,
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [NUM-1:0]   req,
    output logic [NUM-1:0]   grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             any
);

    // Scan from index 0 upward and keep the first request found
    always_comb begin
        logic found;
        found     = 1'b0;
        grant     = '0;
        grant_idx = '0;
        for (int i = 0; i < NUM; i++) begin
            if (req[i] && !found) begin
                found     = 1'b1;
                grant[i]  = 1'b1;
                grant_idx = IDX_W'(i);
            end
        end
        any = found;
    end

    // Grant is at most one bit, follows a request, and exists whenever one does (R3)
    always_comb begin
        assert_grant_onehot_R3: assert ($onehot0(grant))
            else $error("more than one entry granted");
        assert_grant_follows_req_R3: assert ((grant & ~req) == '0)
            else $error("grant without request");
        assert_grant_when_req_R3: assert ((req == '0) || (grant != '0))
            else $error("request present but nothing granted");
        assert_grant_lowest_R3: assert ((grant == '0) || (((grant - 1'b1) & req) == '0))
            else $error("a lower-index request was skipped");
    end

endmodule

// File: rtl/pmpc_decide.sv
// Module: pmpc_decide
// Final verdict: applies the bypass rules, the machine-mode unlocked
// override, the permission test of the selected entry, and the
// no-match default, then forms the cause code.
// Assumes the selected entry fields are meaningful only when sel_valid.
module pmpc_decide
    import pmpc_pkg::*;
(
    input  logic      any_active,
    input  logic      any_locked,
    input  logic      sel_valid,
    input  logic      sel_locked,
    input  perm_t     sel_perm,
    input  logic      priv_m,
    input  logic [1:0] acc_kind,
    output logic      allow,
    output logic [1:0] cause
);

    logic      bypass;
    logic      perm_ok;
    acc_kind_t kind;
    cause_t    fault_code;

    // Decide whether the table is consulted at all
    always_comb begin
        bypass = !any_active || (priv_m && !any_locked);
    end

    // Test the permission bit that matches the access kind
    always_comb begin
        kind = acc_kind_t'(acc_kind);
        unique case (kind)
            ACC_READ:  perm_ok = sel_perm.r;
            ACC_WRITE: perm_ok = sel_perm.w;
            default:   perm_ok = sel_perm.x;
        endcase
    end

    // Combine bypass, selected entry and default into the verdict
    always_comb begin
        if (bypass) begin
            allow = 1'b1;
        end else if (sel_valid) begin
            allow = (priv_m && !sel_locked) || perm_ok;
        end else begin
            allow = priv_m;
        end
    end

    // Map the access kind to the fault cause
    always_comb begin
        unique case (kind)
            ACC_READ:  fault_code = CAUSE_LOAD;
            ACC_WRITE: fault_code = CAUSE_STORE;
            default:   fault_code = CAUSE_INSTR;
        endcase
        cause = allow ? CAUSE_NONE : fault_code;
    end

    // Bypass, unlocked machine hit and machine default all allow (R4, R6, R7)
    always_comb begin
        assert_bypass_allows_R7: assert (!(!any_active || (priv_m && !any_locked)) || allow)
            else $error("bypassed access faulted");
        assert_m_unlocked_allows_R4: assert (!(sel_valid && priv_m && !sel_locked) || allow)
            else $error("unlocked machine-mode hit faulted");
        assert_m_nomatch_allows_R6: assert (!(priv_m && !sel_valid) || allow)
            else $error("machine-mode miss faulted");
        assert_user_nomatch_faults_R6: assert (!(any_active && !priv_m && !sel_valid) || !allow)
            else $error("lower-privilege miss allowed");
    end

endmodule

// File: rtl/pmp_checker.sv
// Module: pmp_checker
// Top of the protection checker. Computes the last byte of the access,
// instantiates one comparator per table entry, picks the lowest-index
// active hit and hands its fields to the decision stage.
// Assumes bounds and configuration bytes are stable for the cycle in
// which allow/fault/cause are consumed; the block holds no state.
module pmp_checker
    import pmpc_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int ADDR_W      = 32,
    parameter int SIZE_W      = 4
) (
    input  logic [ADDR_W-1:0]             acc_addr,
    input  logic [SIZE_W-1:0]             acc_size,
    input  logic [1:0]                    acc_kind,
    input  logic                          priv_m,
    input  logic [NUM_ENTRIES*ADDR_W-1:0] region_lo,
    input  logic [NUM_ENTRIES*ADDR_W-1:0] region_hi,
    input  logic [NUM_ENTRIES*8-1:0]      region_cfg,
    output logic                          allow,
    output logic                          fault,
    output logic [1:0]                    cause
);

    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0]       addr_last;
    logic [SIZE_W-1:0]      size_eff;
    logic [NUM_ENTRIES-1:0] ent_active;
    logic [NUM_ENTRIES-1:0] ent_hit;
    logic [NUM_ENTRIES-1:0] ent_locked;
    perm_t                  ent_perm [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] grant;
    logic [IDX_W-1:0]       grant_idx;
    logic                   sel_valid;
    logic                   sel_locked;
    perm_t                  sel_perm;
    logic                   dec_allow;
    logic [1:0]             dec_cause;

    // Last byte address, one bit wider so a carry past the top never matches
    always_comb begin
        size_eff  = (acc_size == '0) ? SIZE_W'(1) : acc_size;
        addr_last = {1'b0, acc_addr} + EXT_W'(size_eff) - EXT_W'(1);
    end

    // One comparator per table entry
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        pmpc_entry_match #(
            .ADDR_W (ADDR_W)
        ) u_match (
            .addr_first (acc_addr),
            .addr_last  (addr_last),
            .bound_lo   (region_lo[g*ADDR_W +: ADDR_W]),
            .bound_hi   (region_hi[g*ADDR_W +: ADDR_W]),
            .cfg        (region_cfg[g*8 +: 8]),
            .active     (ent_active[g]),
            .hit        (ent_hit[g]),
            .locked     (ent_locked[g]),
            .perm       (ent_perm[g])
        );
    end

    // Lowest-index active hit wins
    pmpc_first_hit #(
        .NUM (NUM_ENTRIES)
    ) u_first (
        .req       (ent_hit),
        .grant     (grant),
        .grant_idx (grant_idx),
        .any       (sel_valid)
    );

    // Fetch the winning entry's fields by index
    always_comb begin
        sel_locked = ent_locked[grant_idx];
        sel_perm   = ent_perm[grant_idx];
    end

    // Verdict and cause
    pmpc_decide u_decide (
        .any_active (|ent_active),
        .any_locked (|ent_locked),
        .sel_valid  (sel_valid),
        .sel_locked (sel_locked),
        .sel_perm   (sel_perm),
        .priv_m     (priv_m),
        .acc_kind   (acc_kind),
        .allow      (dec_allow),
        .cause      (dec_cause)
    );

    // Drive the outputs
    always_comb begin
        allow = dec_allow;
        fault = !dec_allow;
        cause = dec_cause;
    end

    // Output consistency and selection agreement (R8, R3)
    always_comb begin
        assert_fault_inverse_R8: assert (allow != fault)
            else $error("allow and fault agree");
        assert_cause_zero_iff_allow_R8: assert (allow == (cause == 2'd0))
            else $error("cause disagrees with allow");
        assert_idx_matches_grant_R3: assert (!sel_valid || grant[grant_idx])
            else $error("selected index is not the granted entry");
    end

endmodule

// File: tb/tb_pmp_checker.sv
// Bench: tb_pmp_checker
// Directed corner cases followed by seeded random tables and accesses,
// each compared with a reference model written from the requirements.
module tb_pmp_checker;

    localparam int N  = 16;
    localparam int AW = 32;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [AW-1:0]   acc_addr;
    logic [SW-1:0]   acc_size;
    logic [1:0]      acc_kind;
    logic            priv_m;
    logic [N*AW-1:0] region_lo;
    logic [N*AW-1:0] region_hi;
    logic [N*8-1:0]  region_cfg;
    logic            allow;
    logic            fault;
    logic [1:0]      cause;

    pmp_checker #(.NUM_ENTRIES(N), .ADDR_W(AW), .SIZE_W(SW)) dut (
        .acc_addr, .acc_size, .acc_kind, .priv_m,
        .region_lo, .region_hi, .region_cfg,
        .allow, .fault, .cause
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [AW-1:0] t_lo  [N];
    logic [AW-1:0] t_hi  [N];
    logic [7:0]    t_cfg [N];

    // Reference verdict: returns {allow, cause}
    function automatic logic [2:0] ref_model(logic [AW-1:0] a, logic [SW-1:0] sz,
                                             logic [1:0] k, logic pm);
        longint unsigned first, last;
        bit any_act, any_lock, ok;
        logic [1:0] fc;
        fc = (k == 2'd0) ? 2'd1 : (k == 2'd1) ? 2'd2 : 2'd3;
        any_act = 0; any_lock = 0;
        for (int i = 0; i < N; i++) begin
            if (t_cfg[i][4:3] != 2'b00) any_act = 1;
            if (t_cfg[i][7]) any_lock = 1;
        end
        if (!any_act || (pm && !any_lock)) return 3'b100;
        first = longint'(a);
        last  = first + ((sz == 0) ? 0 : longint'(sz) - 1);
        for (int i = 0; i < N; i++) begin
            if (t_cfg[i][4:3] != 2'b00 && first >= longint'(t_lo[i]) && last < longint'(t_hi[i])) begin
                if (pm && !t_cfg[i][7]) ok = 1;
                else if (k == 2'd0) ok = t_cfg[i][0];
                else if (k == 2'd1) ok = t_cfg[i][1];
                else ok = t_cfg[i][2];
                return ok ? 3'b100 : {1'b0, fc};
            end
        end
        return pm ? 3'b100 : {1'b0, fc};
    endfunction

    task automatic clear_table();
        for (int i = 0; i < N; i++) begin
            t_lo[i] = '0; t_hi[i] = '0; t_cfg[i] = '0;
        end
    endtask

    task automatic load_table();
        for (int i = 0; i < N; i++) begin
            region_lo[i*AW +: AW] = t_lo[i];
            region_hi[i*AW +: AW] = t_hi[i];
            region_cfg[i*8 +: 8]  = t_cfg[i];
        end
    endtask

    // Drive one access after a falling edge, sample before the next rising edge
    task automatic probe(string tag, logic [AW-1:0] a, logic [SW-1:0] sz,
                         logic [1:0] k, logic pm);
        logic [2:0] exp_v;
        load_table();
        @(negedge clk);
        acc_addr = a; acc_size = sz; acc_kind = k; priv_m = pm;
        #2;
        exp_v = ref_model(a, sz, k, pm);
        checks++;
        if (allow !== exp_v[2] || fault !== !exp_v[2] || cause !== exp_v[1:0]) begin
            failures++;
            $display("FAIL %s addr=%h size=%0d kind=%0d m=%0d: got allow=%b fault=%b cause=%0d, expected allow=%b fault=%b cause=%0d",
                     tag, a, sz, k, pm, allow, fault, cause, exp_v[2], !exp_v[2], exp_v[1:0]);
        end
    endtask

    initial begin
        #1600000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired: got running, expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        clear_table();
        acc_addr = '0; acc_size = '0; acc_kind = '0; priv_m = 1'b0;
        load_table();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset state: empty table, lower privilege bypasses (R7)
        probe("R7 empty table user read", 32'h40, 4, 2'd0, 1'b0);

        // R1: bounds inclusive-low, exclusive-high, both ends checked
        t_lo[0] = 32'h100; t_hi[0] = 32'h200; t_cfg[0] = 8'h09;      // mode 1, R
        probe("R1 last byte at top-1",    32'h1F8, 8, 2'd0, 1'b0);
        probe("R1 straddles upper bound", 32'h1F8, 9, 2'd0, 1'b0);
        probe("R1 at exclusive bound",    32'h200, 1, 2'd0, 1'b0);
        probe("R1 below lower bound",     32'h0FF, 2, 2'd0, 1'b0);
        probe("R1 size zero as one byte", 32'h1FF, 0, 2'd0, 1'b0);
        clear_table();
        t_lo[0] = 32'hFFFF_FF00; t_hi[0] = 32'hFFFF_FFFF; t_cfg[0] = 8'h0F;
        probe("R1 carry past top",        32'hFFFF_FFFC, 8, 2'd2, 1'b0);

        // R2: off entry ignored, active one behind it decides
        clear_table();
        t_lo[0] = 32'h0; t_hi[0] = 32'h1000; t_cfg[0] = 8'h07;        // off, RWX
        t_lo[1] = 32'h0; t_hi[1] = 32'h1000; t_cfg[1] = 8'h0A;        // active, W
        probe("R2 off entry skipped read", 32'h80, 4, 2'd0, 1'b0);
        probe("R2 active entry write",     32'h80, 4, 2'd1, 1'b0);

        // R3: lowest index wins
        clear_table();
        t_lo[3] = 32'h200; t_hi[3] = 32'h300; t_cfg[3] = 8'h19;       // R
        t_lo[4] = 32'h200; t_hi[4] = 32'h300; t_cfg[4] = 8'h1F;       // RWX
        probe("R3 lower entry denies write", 32'h210, 4, 2'd1, 1'b0);
        probe("R3 lower entry allows read",  32'h210, 4, 2'd0, 1'b0);

        // R4 and R5 in machine mode with a lock elsewhere
        clear_table();
        t_lo[0] = 32'h100; t_hi[0] = 32'h140; t_cfg[0] = 8'h08;       // unlocked, no perms
        t_lo[1] = 32'h400; t_hi[1] = 32'h500; t_cfg[1] = 8'h89;       // locked, R
        probe("R4 unlocked machine exec",   32'h100, 4, 2'd2, 1'b1);
        probe("R5 locked machine write",    32'h410, 4, 2'd1, 1'b1);
        probe("R5 locked machine read",     32'h410, 4, 2'd0, 1'b1);
        probe("R5 user exec without X",     32'h120, 4, 2'd2, 1'b0);
        probe("R5 reserved kind as exec",   32'h410, 4, 2'd3, 1'b1);
        t_cfg[0] = 8'h0C;                                             // X only
        probe("R5 user exec with X",        32'h120, 4, 2'd2, 1'b0);

        // R6: no match
        probe("R6 user miss exec",    32'h800, 4, 2'd2, 1'b0);
        probe("R6 user miss write",   32'h800, 4, 2'd1, 1'b0);
        probe("R6 machine miss",      32'h800, 4, 2'd1, 1'b1);

        // R7: machine bypass with no lock, and lock on an off entry still counts
        clear_table();
        t_lo[2] = 32'h0; t_hi[2] = 32'h100; t_cfg[2] = 8'h88;         // locked, no perms
        t_cfg[2] = 8'h08;
        probe("R7 machine no lock bypass", 32'h10, 4, 2'd1, 1'b1);
        t_cfg[2] = 8'h88;
        probe("R7 lock engages check", 32'h10, 4, 2'd1, 1'b1);
        t_cfg[2] = 8'h08; t_cfg[5] = 8'h80;                           // lock on off entry
        t_lo[6] = 32'h0; t_hi[6] = 32'h100; t_cfg[6] = 8'h80;
        probe("R7 off-entry lock counts", 32'h10, 4, 2'd1, 1'b1);

        // R8: cause per kind on fault, zero on allow
        clear_table();
        t_lo[0] = 32'h0; t_hi[0] = 32'h100; t_cfg[0] = 8'h10;
        probe("R8 load cause",  32'h20, 4, 2'd0, 1'b0);
        probe("R8 store cause", 32'h20, 4, 2'd1, 1'b0);
        probe("R8 instr cause", 32'h20, 4, 2'd2, 1'b0);

        // Random phase: small window for frequent overlaps
        for (int it = 0; it < 3000; it++) begin
            if (it % 20 == 0) begin
                for (int i = 0; i < N; i++) begin
                    t_lo[i]  = $urandom_range(0, 32'h3FF);
                    t_hi[i]  = t_lo[i] + $urandom_range(0, 32'h100);
                    t_cfg[i] = 8'($urandom);
                    if ($urandom_range(0, 3) != 0) t_cfg[i][7] = 1'b0;
                end
            end
            probe("RAND mixed", $urandom_range(0, 32'h4FF), SW'($urandom),
                  2'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule